// File: doc/BRIEF.md
# Interrupt Distributor State Bank

This block keeps the per-interrupt bookkeeping of a small interrupt distributor: an enable bit, a pending bit, an active bit, a trigger mode and a priority byte for each interrupt, plus a sampled copy of each interrupt's input line. Software reaches all of it through a word-wide memory-mapped bus. For the one-bit states, writes use separate set and clear registers, so that a bit is changed only where a 1 is written.

The pending state depends on the trigger mode. An edge-triggered interrupt latches pending on a rising edge of its line, and a pending-clear write drops it. A level-triggered interrupt shows pending as the sampled line OR a software latch. A pending-set write arms that latch and a pending-clear write disarms it. Because the latch is kept apart from the line, a clear can never hide a line that is still asserted, and a software request survives trigger mode changes. The lowest 32 interrupts are private, and their trigger mode is fixed at level.

The enable, pending and active vectors are also brought out as ports for the arbitration logic that follows. Reads return data one cycle after the request.

Top module: `dist_state_bank`

## Requirements
- R1: A write of 1 bits to an enable-set word (word address 0 to 1) sets the matching enable bits. A write to an enable-clear word (word address 2 to 3) clears them. Bits written 0 leave state unchanged. A read of either word of a pair returns the current enable bits.
- R2: In a one-bit-per-interrupt word of index w within its group, bit b belongs to interrupt 32*w+b. With 64 interrupts, the groups are enable set 0-1, enable clear 2-3, pending set 4-5, pending clear 6-7, active set 8-9 and active clear 10-11.
- R3: A pending-set write (word address 4 to 5) sets pending on any interrupt. On a level interrupt it also arms a software latch, and pending then stays 1 while the line is low.
- R4: A pending-clear write (word address 6 to 7) has a different effect for each trigger mode. On a level interrupt it disarms the software latch, and pending then equals the sampled line. On an edge interrupt it clears pending even while the line stays high.
- R5: Trigger configuration words (word address 12 to 15) hold 16 interrupts each, with two bits per interrupt at bit 2*k for interrupt 16*word+k. Only the upper bit of each pair is stored: 1 means edge and 0 means level. A read returns 2'b10 for edge and 2'b00 for level.
- R6: When an interrupt changes to level, its pending becomes line OR software latch. When it changes to edge, the pending value it had is kept.
- R7: Configuration writes to interrupts 0 to 31 are ignored, and those interrupts read back as level.
- R8: Priority words (word address 16 to 31) hold four interrupts each, one byte per interrupt, with the lowest-numbered interrupt in bits 7:0. Only the top PRI_BITS bits of each byte are stored (5 by default), and the lower bits read as 0.
- R9: After reset, every enable, pending, active and priority value reads 0, and every interrupt is level.
- R10: On an edge interrupt, a rising line sets pending whether or not the interrupt is enabled. On a level interrupt, pending follows the line one cycle after sampling.
- R11: Active-set writes (word address 8 to 9) set active bits, and active-clear writes (word address 10 to 11) clear them.
- R12: The read valid output and the read data arrive one cycle after a read request. Addresses 32 and above read as 0 and ignore writes.
- R13: The irq_enabled, irq_pending and irq_active ports match the state that bus reads return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| irq_line | input | NUM_IRQ | Interrupt input lines |
| irq_enabled | output | NUM_IRQ | Enable state per interrupt |
| irq_pending | output | NUM_IRQ | Pending state per interrupt |
| irq_active | output | NUM_IRQ | Active state per interrupt |

## Verification
The hardest state to reach is a software latch that is armed but invisible. An interrupt is set pending while it is level, moved to edge, and cleared there, so pending reads 0 while the latch stays armed. The stimulus then returns the interrupt to level with its line low. Pending must come back as 1, and this shows that the latch survived both the mode change and the edge-mode clear. The edge path is also exercised with a line that stays high across a clear, so that no new rising edge appears. The line is then dropped and raised again.

// File: rtl/dist_pkg.sv
package dist_pkg;

  localparam int DATA_W = 32;

  typedef enum logic [3:0] {
    RG_NONE,
    RG_EN_SET,
    RG_EN_CLR,
    RG_PD_SET,
    RG_PD_CLR,
    RG_AC_SET,
    RG_AC_CLR,
    RG_CFG,
    RG_PRI
  } region_e;

  function automatic logic [7:0] pri_keep_mask(input int pri_bits);
    logic [7:0] m;
    m = '0;
    for (int b = 0; b < 8; b++) begin
      if (b >= 8 - pri_bits) m[b] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/dist_decode.sv
module dist_decode
  import dist_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int ADDR_W  = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [31:0]       wdata,
  output region_e           region,
  output logic [ADDR_W-1:0] offset,
  output logic [NUM_IRQ-1:0] set_en,
  output logic [NUM_IRQ-1:0] clr_en,
  output logic [NUM_IRQ-1:0] set_pd,
  output logic [NUM_IRQ-1:0] clr_pd,
  output logic [NUM_IRQ-1:0] set_ac,
  output logic [NUM_IRQ-1:0] clr_ac,
  output logic [NUM_IRQ-1:0] cfg_we,
  output logic [NUM_IRQ-1:0] cfg_edge,
  output logic              prio_we
);
  localparam int W1       = NUM_IRQ / 32;
  localparam int WC       = NUM_IRQ / 16;
  localparam int WP       = NUM_IRQ / 4;
  localparam int B_EN_SET = 0;
  localparam int B_EN_CLR = W1;
  localparam int B_PD_SET = 2 * W1;
  localparam int B_PD_CLR = 3 * W1;
  localparam int B_AC_SET = 4 * W1;
  localparam int B_AC_CLR = 5 * W1;
  localparam int B_CFG    = 6 * W1;
  localparam int B_PRI    = 6 * W1 + WC;
  localparam int B_END    = B_PRI + WP;

  logic [31:0]        a_ext;
  logic [31:0]        base;
  logic [NUM_IRQ-1:0] bitv;

  always_comb begin
    a_ext = 32'(addr);
    if (a_ext < B_EN_CLR) begin
      region = RG_EN_SET; base = B_EN_SET;
    end else if (a_ext < B_PD_SET) begin
      region = RG_EN_CLR; base = B_EN_CLR;
    end else if (a_ext < B_PD_CLR) begin
      region = RG_PD_SET; base = B_PD_SET;
    end else if (a_ext < B_AC_SET) begin
      region = RG_PD_CLR; base = B_PD_CLR;
    end else if (a_ext < B_AC_CLR) begin
      region = RG_AC_SET; base = B_AC_SET;
    end else if (a_ext < B_CFG) begin
      region = RG_AC_CLR; base = B_AC_CLR;
    end else if (a_ext < B_PRI) begin
      region = RG_CFG; base = B_CFG;
    end else if (a_ext < B_END) begin
      region = RG_PRI; base = B_PRI;
    end else begin
      region = RG_NONE; base = a_ext;
    end
    offset = ADDR_W'(a_ext - base);
  end

  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++) begin
      bitv[i]     = (32'(offset) == 32'(i / 32)) ? wdata[i % 32] : 1'b0;
      cfg_we[i]   = wr && (region == RG_CFG) && (32'(offset) == 32'(i / 16));
      cfg_edge[i] = wdata[2 * (i % 16) + 1];
    end
    set_en  = (wr && region == RG_EN_SET) ? bitv : '0;
    clr_en  = (wr && region == RG_EN_CLR) ? bitv : '0;
    set_pd  = (wr && region == RG_PD_SET) ? bitv : '0;
    clr_pd  = (wr && region == RG_PD_CLR) ? bitv : '0;
    set_ac  = (wr && region == RG_AC_SET) ? bitv : '0;
    clr_ac  = (wr && region == RG_AC_CLR) ? bitv : '0;
    prio_we = wr && (region == RG_PRI);
  end

  // R2: one write touches at most one register group
  always_comb begin
    assert ($onehot0({|set_en, |clr_en, |set_pd, |clr_pd, |set_ac, |clr_ac,
                      |cfg_we, prio_we}))
      else $error("p_one_group_r2");
    // R12: unmapped addresses produce no strobes
    if (region == RG_NONE)
      assert (!(|{set_en, clr_en, set_pd, clr_pd, set_ac, clr_ac, cfg_we}) && !prio_we)
        else $error("p_unmapped_quiet_r12");
  end

endmodule

// File: rtl/dist_irq_cell.sv
module dist_irq_cell #(
  parameter bit PRIVATE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic line,
  input  logic set_en,
  input  logic clr_en,
  input  logic set_pd,
  input  logic clr_pd,
  input  logic set_ac,
  input  logic clr_ac,
  input  logic cfg_we,
  input  logic cfg_edge,
  output logic enabled,
  output logic pending,
  output logic active,
  output logic edge_cfg
);
  logic en_q, ac_q, soft_q, pe_q, ln_q, ed_q;
  logic ed_next, pe_next, rise;

  assign rise = line & ~ln_q;

  generate
    if (PRIVATE) begin : g_fixed
      wire unused_cfg = cfg_we | cfg_edge;
      assign ed_next = 1'b0;
    end else begin : g_prog
      assign ed_next = cfg_we ? cfg_edge : ed_q;
    end
  endgenerate

  always_comb begin
    pe_next = pe_q;
    if (ed_next && !ed_q) pe_next = ln_q | soft_q;
    if (ed_q && set_pd)   pe_next = 1'b1;
    if (ed_q && clr_pd)   pe_next = 1'b0;
    if (ed_next && rise)  pe_next = 1'b1;
    if (!ed_next)         pe_next = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      ac_q   <= 1'b0;
      soft_q <= 1'b0;
      pe_q   <= 1'b0;
      ln_q   <= 1'b0;
      ed_q   <= 1'b0;
    end else begin
      ln_q <= line;
      ed_q <= ed_next;
      pe_q <= pe_next;
      if (set_en)      en_q <= 1'b1;
      else if (clr_en) en_q <= 1'b0;
      if (set_ac)      ac_q <= 1'b1;
      else if (clr_ac) ac_q <= 1'b0;
      if (set_pd && !ed_q)      soft_q <= 1'b1;
      else if (clr_pd && !ed_q) soft_q <= 1'b0;
    end
  end

  assign enabled  = en_q;
  assign active   = ac_q;
  assign edge_cfg = ed_q;
  assign pending  = ed_q ? pe_q : (ln_q | soft_q);

  p_en_set_r1: assert property (@(posedge clk) disable iff (rst)
    set_en |=> enabled);
  p_en_clr_r1: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> !enabled);
  p_act_set_r11: assert property (@(posedge clk) disable iff (rst)
    set_ac |=> active);
  p_act_clr_r11: assert property (@(posedge clk) disable iff (rst)
    clr_ac |=> !active);
  p_set_pend_r3: assert property (@(posedge clk) disable iff (rst)
    set_pd |=> pending);
  p_edge_rise_r10: assert property (@(posedge clk) disable iff (rst)
    (edge_cfg && !cfg_we && line && !ln_q) |=> pending);
  p_edge_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (edge_cfg && !cfg_we && clr_pd && !(line && !ln_q)) |=> !pending);
  p_level_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (!edge_cfg && !cfg_we && clr_pd) |=> (pending == $past(line)));

endmodule

// File: rtl/dist_prio_ram.sv
module dist_prio_ram
  import dist_pkg::*;
#(
  parameter int NUM_IRQ  = 64,
  parameter int PRI_BITS = 5,
  parameter int ADDR_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] idx,
  input  logic [31:0]       wdata,
  input  logic              rd,
  output logic [31:0]       rdata
);
  localparam int WP    = NUM_IRQ / 4;
  localparam int IDX_W = (WP > 1) ? $clog2(WP) : 1;
  localparam logic [7:0] KEEP = pri_keep_mask(PRI_BITS);

  logic [31:0]   mem [WP];
  logic [WP-1:0] written_q;
  logic [31:0]   dout_q;
  logic          dvalid_q;
  logic [IDX_W-1:0] a;

  assign a = IDX_W'(idx);

  always_ff @(posedge clk) begin
    if (we) mem[a] <= wdata & {4{KEEP}};
    dout_q <= mem[a];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      written_q <= '0;
      dvalid_q  <= 1'b0;
    end else begin
      if (we) written_q[a] <= 1'b1;
      dvalid_q <= written_q[a];
    end
  end

  assign rdata = dvalid_q ? dout_q : 32'd0;

  p_prio_low_r8: assert property (@(posedge clk) disable iff (rst)
    rd |=> ((rdata & ~{4{KEEP}}) == 32'd0));

endmodule

// File: rtl/dist_state_bank.sv
module dist_state_bank
  import dist_pkg::*;
#(
  parameter int NUM_IRQ  = 64,
  parameter int NUM_PRIV = 32,
  parameter int PRI_BITS = 5,
  parameter int ADDR_W   = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_rvalid,
  input  logic [NUM_IRQ-1:0] irq_line,
  output logic [NUM_IRQ-1:0] irq_enabled,
  output logic [NUM_IRQ-1:0] irq_pending,
  output logic [NUM_IRQ-1:0] irq_active
);
  region_e            region;
  logic [ADDR_W-1:0]  offset;
  logic [NUM_IRQ-1:0] set_en, clr_en, set_pd, clr_pd, set_ac, clr_ac;
  logic [NUM_IRQ-1:0] cfg_we, cfg_edge, edge_cfg;
  logic               prio_we;
  logic [31:0]        word_c, word_q, prio_dout;
  region_e            region_q;
  logic               rvalid_q;

  dist_decode #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .region(region), .offset(offset),
    .set_en(set_en), .clr_en(clr_en), .set_pd(set_pd), .clr_pd(clr_pd),
    .set_ac(set_ac), .clr_ac(clr_ac), .cfg_we(cfg_we), .cfg_edge(cfg_edge),
    .prio_we(prio_we)
  );

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_cell
    dist_irq_cell #(.PRIVATE(i < NUM_PRIV)) u_cell (
      .clk(clk), .rst(rst), .line(irq_line[i]),
      .set_en(set_en[i]), .clr_en(clr_en[i]),
      .set_pd(set_pd[i]), .clr_pd(clr_pd[i]),
      .set_ac(set_ac[i]), .clr_ac(clr_ac[i]),
      .cfg_we(cfg_we[i]), .cfg_edge(cfg_edge[i]),
      .enabled(irq_enabled[i]), .pending(irq_pending[i]),
      .active(irq_active[i]), .edge_cfg(edge_cfg[i])
    );
  end

  dist_prio_ram #(.NUM_IRQ(NUM_IRQ), .PRI_BITS(PRI_BITS), .ADDR_W(ADDR_W)) u_prio (
    .clk(clk), .rst(rst), .we(prio_we), .idx(offset), .wdata(bus_wdata),
    .rd(bus_rd && region == RG_PRI), .rdata(prio_dout)
  );

  always_comb begin
    word_c = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (32'(offset) == 32'(i / 32)) begin
        case (region)
          RG_EN_SET, RG_EN_CLR: word_c[i % 32] = irq_enabled[i];
          RG_PD_SET, RG_PD_CLR: word_c[i % 32] = irq_pending[i];
          RG_AC_SET, RG_AC_CLR: word_c[i % 32] = irq_active[i];
          default: ;
        endcase
      end
      if (region == RG_CFG && 32'(offset) == 32'(i / 16))
        word_c[2 * (i % 16) + 1] = edge_cfg[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      word_q   <= '0;
      region_q <= RG_NONE;
    end else begin
      rvalid_q <= bus_rd;
      word_q   <= word_c;
      region_q <= region;
    end
  end

  assign bus_rvalid = rvalid_q;
  assign bus_rdata  = (region_q == RG_PRI) ? prio_dout : word_q;

  p_rvalid_r12: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
  p_no_rvalid_r12: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);
  p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && region == RG_NONE) |=> (bus_rdata == 32'd0));
  p_priv_level_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && region == RG_CFG && 32'(offset) < 32'(NUM_PRIV / 16)) |=> (bus_rdata == 32'd0));

endmodule

// File: tb/dist_state_bank_bench.sv
module dist_state_bank_bench;
  localparam int NUM_IRQ = 64;
  localparam int ADDR_W  = 6;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               bus_wr = 1'b0, bus_rd = 1'b0;
  logic [ADDR_W-1:0]  bus_addr = '0;
  logic [31:0]        bus_wdata = '0;
  logic [31:0]        bus_rdata;
  logic               bus_rvalid;
  logic [NUM_IRQ-1:0] irq_line = '0;
  logic [NUM_IRQ-1:0] irq_enabled, irq_pending, irq_active;

  int total = 0;
  int bad   = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  dist_state_bank u_dist_state_bank (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq_line(irq_line), .irq_enabled(irq_enabled),
    .irq_pending(irq_pending), .irq_active(irq_active)
  );

  // monitor: compare read results against the scoreboard
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R12 unexpected rvalid act=%h exp=none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          bad++;
          $display("FAIL %s act=%h exp=%h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = ADDR_W'(a);
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk(input logic act, input logic e, input string t);
    total++;
    if (act !== e) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", t, act, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R9 reset state
    rd(0, 32'h0, "R9 enable");
    rd(5, 32'h0, "R9 pending");
    rd(14, 32'h0, "R9 config level");
    rd(16, 32'h0, "R9 priority");
    rd(31, 32'h0, "R9 priority top");
    idle(1);
    chk(|irq_pending, 1'b0, "R9 pending port");
    // R1 enable set/clear
    wr(0, 32'h0000_00F0);
    rd(0, 32'h0000_00F0, "R1 set read");
    rd(2, 32'h0000_00F0, "R1 clear-reg read");
    wr(2, 32'h0000_0030);
    rd(0, 32'h0000_00C0, "R1 clear");
    wr(0, 32'h0);
    rd(0, 32'h0000_00C0, "R1 zero no effect");
    // R2 mapping to upper word
    wr(1, 32'h8000_0001);
    rd(1, 32'h8000_0001, "R2 word1 map");
    idle(1);
    chk(irq_enabled[32], 1'b1, "R2 R13 irq32 enabled");
    chk(irq_enabled[63], 1'b1, "R2 R13 irq63 enabled");
    chk(irq_enabled[31], 1'b0, "R2 irq31 untouched");
    // R11 active
    wr(8, 32'h5);
    rd(10, 32'h5, "R11 active set");
    wr(10, 32'h4);
    rd(8, 32'h1, "R11 active clear");
    idle(1);
    chk(irq_active[0], 1'b1, "R13 active port");
    // R5 / R7 configuration
    wr(14, 32'hFFFF_FFFF);
    rd(14, 32'hAAAA_AAAA, "R5 edge readback");
    wr(12, 32'hFFFF_FFFF);
    rd(12, 32'h0, "R7 private ignored");
    wr(13, 32'hAAAA_AAAA);
    rd(13, 32'h0, "R7 private upper ignored");
    wr(15, 32'h0000_0003);
    rd(15, 32'h0000_0002, "R5 irq48 edge");
    // R10 / R4 edge behaviour on irq32
    irq_line[32] = 1'b1;
    idle(2);
    rd(5, 32'h1, "R10 edge rise pending");
    chk(irq_pending[32], 1'b1, "R13 pending port");
    wr(7, 32'h1);
    rd(5, 32'h0, "R4 edge clear with line high");
    irq_line[32] = 1'b0;
    idle(2);
    irq_line[32] = 1'b1;
    idle(2);
    rd(5, 32'h1, "R10 second rise");
    wr(7, 32'h1);
    irq_line[32] = 1'b0;
    rd(5, 32'h0, "R4 edge clear again");
    // R10 level tracking on irq50
    irq_line[50] = 1'b1;
    idle(2);
    rd(5, 32'h0004_0000, "R10 level high");
    irq_line[50] = 1'b0;
    idle(2);
    rd(5, 32'h0, "R10 level low");
    // R3 / R4 level software latch
    wr(5, 32'h0004_0000);
    idle(2);
    rd(5, 32'h0004_0000, "R3 soft pending holds");
    irq_line[50] = 1'b1;
    idle(2);
    wr(7, 32'h0004_0000);
    rd(5, 32'h0004_0000, "R4 level clear follows line");
    irq_line[50] = 1'b0;
    idle(2);
    rd(5, 32'h0, "R4 latch disarmed");
    // R6 latch hidden across edge mode on irq51
    wr(5, 32'h0008_0000);
    rd(5, 32'h0008_0000, "R3 irq51 soft");
    wr(15, 32'h0000_0082);
    rd(5, 32'h0008_0000, "R6 to edge keeps pending");
    rd(15, 32'h0000_0082, "R5 cfg word");
    wr(7, 32'h0008_0000);
    rd(5, 32'h0, "R4 edge clear hides latch");
    wr(15, 32'h0000_0002);
    rd(5, 32'h0008_0000, "R6 back to level restores");
    wr(7, 32'h0008_0000);
    rd(5, 32'h0, "R4 level clear line low");
    // R8 priority
    wr(16, 32'hFFFF_FFFF);
    rd(16, 32'hF8F8_F8F8, "R8 low bits forced 0");
    wr(31, 32'h1234_5678);
    rd(31, 32'h1030_5078, "R8 byte order");
    rd(17, 32'h0, "R8 unwritten word");
    // R12 unmapped
    rd(40, 32'h0, "R12 unmapped read");
    wr(40, 32'hFFFF_FFFF);
    rd(0, 32'h0000_00C0, "R12 unmapped write ignored");
    rd(16, 32'hF8F8_F8F8, "R12 prio untouched");
    idle(1);
    chk(bus_rvalid, 1'b0, "R12 no rvalid without read");
    idle(4);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R12 missing responses act=%0d exp=0", exp_q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule